// File: doc/BRIEF.md
# In-band transmit XON/XOFF inserter

This block decides when the local receiver must ask the far end to pause or resume. It watches the receive FIFO fill level against two programmable trigger thresholds. When the level rises above the upper threshold, it raises a request to put a stop character into the outgoing serial stream. It raises a go character once the level has drained below the lower threshold. The gap between the two thresholds gives hysteresis, so a level near one threshold does not cause a stream of requests.

The transmitter sees a request, a character and a throttled flag. It gives the request precedence over its next queued data byte and acknowledges it with a ready pulse. A two-bit mode code selects which of two programmed character pairs is used, or turns insertion off. Insertion also runs only with the enhanced-feature enable set and with 9-bit framing off.

Top module: `xonxoff_inserter`

## Requirements
- R1: After reset, `ins_req_o` and `throttled_o` are 0.
- R2: The block is active when `enh_en_i` is 1, `nine_bit_i` is 0 and `tx_mode_i` is 2'b01 or 2'b10. When it is active and not throttled, and `rx_level_i > thr_hi_i` is sampled at a clock edge with no request pending, `ins_req_o` is 1 after that edge. `ins_char_o` is then `xoff2_i` for mode 2'b01 and `xoff1_i` for mode 2'b10.
- R3: When the block is active and throttled, and `rx_level_i < thr_lo_i` is sampled with no request pending, `ins_req_o` is 1 after that edge. `ins_char_o` is then `xon2_i` for mode 2'b01 and `xon1_i` for mode 2'b10.
- R4: While the block is active, a raised request stays high, with `ins_char_o` unchanged, until `ins_ready_i` is sampled high together with it. The request is 0 after that edge.
- R5: An accepted stop character sets `throttled_o` and an accepted go character clears it. `throttled_o` changes in no other way while the block is active. No second stop character is requested while throttled, and no go character is requested while not throttled.
- R6: A level from `thr_lo_i` up to and including `thr_hi_i` raises no request in either state.
- R7: Mode codes 2'b00 and the reserved 2'b11, `enh_en_i` = 0, or `nine_bit_i` = 1 keep `ins_req_o` at 0.
- R8: When the block becomes inactive, `throttled_o` and any pending request are cleared at the next edge, and no character is sent.
- R9: When the block becomes inactive in the same cycle as an acceptance, the inactive state wins: `throttled_o` ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| thr_hi_i | input | LVL_W | Upper trigger threshold |
| thr_lo_i | input | LVL_W | Lower trigger threshold |
| enh_en_i | input | 1 | Enhanced-feature enable |
| nine_bit_i | input | 1 | 9-bit framing active |
| tx_mode_i | input | 2 | Character set select: 00 off, 01 set 2, 10 set 1, 11 reserved |
| xon1_i | input | 8 | Go character, set 1 |
| xon2_i | input | 8 | Go character, set 2 |
| xoff1_i | input | 8 | Stop character, set 1 |
| xoff2_i | input | 8 | Stop character, set 2 |
| ins_ready_i | input | 1 | Transmitter accepts the pending character |
| ins_req_o | output | 1 | Insertion request |
| ins_char_o | output | 8 | Character to insert |
| throttled_o | output | 1 | Far end has been told to stop |

## Verification
Acceptance of a pending character can fall in the same cycle as a mode change that makes the block inactive. It can also fall in the same cycle as a level that would start the opposite request. The bench provokes the first case by dropping the mode to 2'b00 on the very cycle a stop character is acknowledged, and expects `throttled_o` to stay 0 (R9). It provokes the second by holding the level below the lower threshold while a stop character is acknowledged, and expects the go request one cycle after the acknowledgement, never in the same cycle. A long pseudo-random run with ready and mode toggling is compared cycle by cycle against a reference model built from the requirements.

// File: rtl/xio_pkg.sv
package xio_pkg;
  parameter int CHR_W = 8;

  typedef enum logic [1:0] {
    TXM_OFF  = 2'b00,
    TXM_SET2 = 2'b01,
    TXM_SET1 = 2'b10,
    TXM_RSVD = 2'b11
  } txm_e;
endpackage

// File: rtl/xio_mode_dec.sv
module xio_mode_dec
  import xio_pkg::*;
(
  input  logic             enh_en_i,
  input  logic             nine_bit_i,
  input  logic [1:0]       mode_i,
  input  logic [CHR_W-1:0] xon1_i,
  input  logic [CHR_W-1:0] xon2_i,
  input  logic [CHR_W-1:0] xoff1_i,
  input  logic [CHR_W-1:0] xoff2_i,
  output logic             active_o,
  output logic [CHR_W-1:0] xon_chr_o,
  output logic [CHR_W-1:0] xoff_chr_o
);
  logic mode_ok;

  always_comb begin
    mode_ok    = 1'b0;
    xon_chr_o  = xon1_i;
    xoff_chr_o = xoff1_i;
    case (txm_e'(mode_i))
      TXM_SET2: begin
        mode_ok    = 1'b1;
        xon_chr_o  = xon2_i;
        xoff_chr_o = xoff2_i;
      end
      TXM_SET1: mode_ok = 1'b1;
      default:  mode_ok = 1'b0; // off and reserved
    endcase
  end

  assign active_o = mode_ok & enh_en_i & ~nine_bit_i;
endmodule

// File: rtl/xio_level_cmp.sv
module xio_level_cmp #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_hi_i,
  input  logic [LVL_W-1:0] thr_lo_i,
  output logic             above_o,
  output logic             below_o
);
  assign above_o = level_i > thr_hi_i;
  assign below_o = level_i < thr_lo_i;
endmodule

// File: rtl/xio_flow_fsm.sv
module xio_flow_fsm
  import xio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             above_i,
  input  logic             below_i,
  input  logic [CHR_W-1:0] xon_chr_i,
  input  logic [CHR_W-1:0] xoff_chr_i,
  input  logic             ready_i,
  output logic             req_o,
  output logic [CHR_W-1:0] chr_o,
  output logic             throttled_o
);
  logic pend_xoff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o       <= 1'b0;
      pend_xoff_q <= 1'b0;
      chr_o       <= '0;
      throttled_o <= 1'b0;
    end else if (!active_i) begin
      // leaving the active state drops everything silently
      req_o       <= 1'b0;
      throttled_o <= 1'b0;
    end else if (req_o && ready_i) begin
      req_o       <= 1'b0;
      throttled_o <= pend_xoff_q;
    end else if (!req_o) begin
      if (!throttled_o && above_i) begin
        req_o       <= 1'b1;
        pend_xoff_q <= 1'b1;
        chr_o       <= xoff_chr_i;
      end else if (throttled_o && below_i) begin
        req_o       <= 1'b1;
        pend_xoff_q <= 1'b0;
        chr_o       <= xon_chr_i;
      end
    end
  end
endmodule

// File: rtl/xonxoff_inserter.sv
module xonxoff_inserter
  import xio_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] thr_hi_i,
  input  logic [LVL_W-1:0] thr_lo_i,
  input  logic             enh_en_i,
  input  logic             nine_bit_i,
  input  logic [1:0]       tx_mode_i,
  input  logic [7:0]       xon1_i,
  input  logic [7:0]       xon2_i,
  input  logic [7:0]       xoff1_i,
  input  logic [7:0]       xoff2_i,
  input  logic             ins_ready_i,
  output logic             ins_req_o,
  output logic [7:0]       ins_char_o,
  output logic             throttled_o
);
  logic             active;
  logic             above;
  logic             below;
  logic [CHR_W-1:0] xon_chr;
  logic [CHR_W-1:0] xoff_chr;

  xio_mode_dec u_dec (
    .enh_en_i   (enh_en_i),
    .nine_bit_i (nine_bit_i),
    .mode_i     (tx_mode_i),
    .xon1_i     (xon1_i),
    .xon2_i     (xon2_i),
    .xoff1_i    (xoff1_i),
    .xoff2_i    (xoff2_i),
    .active_o   (active),
    .xon_chr_o  (xon_chr),
    .xoff_chr_o (xoff_chr)
  );

  xio_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level_i  (rx_level_i),
    .thr_hi_i (thr_hi_i),
    .thr_lo_i (thr_lo_i),
    .above_o  (above),
    .below_o  (below)
  );

  xio_flow_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .above_i     (above),
    .below_i     (below),
    .xon_chr_i   (xon_chr),
    .xoff_chr_i  (xoff_chr),
    .ready_i     (ins_ready_i),
    .req_o       (ins_req_o),
    .chr_o       (ins_char_o),
    .throttled_o (throttled_o)
  );
endmodule

// File: rtl/xio_inserter_chk.sv
module xio_inserter_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [LVL_W-1:0] thr_hi_i,
  input logic [LVL_W-1:0] thr_lo_i,
  input logic             enh_en_i,
  input logic             nine_bit_i,
  input logic [1:0]       tx_mode_i,
  input logic             ins_ready_i,
  input logic             ins_req_o,
  input logic [7:0]       ins_char_o,
  input logic             throttled_o
);
  logic act;
  assign act = enh_en_i && !nine_bit_i && (tx_mode_i == 2'b01 || tx_mode_i == 2'b10);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_req_o && !ins_ready_i && act |=> ins_req_o && $stable(ins_char_o)); // R4
  AST_ACCEPT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_req_o && ins_ready_i |=> !ins_req_o); // R4
  AST_XOFF_THROTTLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_req_o && ins_ready_i && !throttled_o && act |=> throttled_o); // R5
  AST_THR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && !(ins_req_o && ins_ready_i) |=> $stable(throttled_o)); // R5
  AST_XOFF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ins_req_o) && !throttled_o |-> $past(rx_level_i > thr_hi_i)); // R2
  AST_XON_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ins_req_o) && throttled_o |-> $past(rx_level_i < thr_lo_i)); // R3
  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> !ins_req_o && !throttled_o); // R7
endmodule

bind xonxoff_inserter xio_inserter_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_level_i  (rx_level_i),
  .thr_hi_i    (thr_hi_i),
  .thr_lo_i    (thr_lo_i),
  .enh_en_i    (enh_en_i),
  .nine_bit_i  (nine_bit_i),
  .tx_mode_i   (tx_mode_i),
  .ins_ready_i (ins_ready_i),
  .ins_req_o   (ins_req_o),
  .ins_char_o  (ins_char_o),
  .throttled_o (throttled_o)
);

// File: tb/xonxoff_inserter_tb.sv
module xonxoff_inserter_tb;
  localparam int CLK_P = 10;
  localparam int LVL_W = 8;
  localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h12, XOFF1 = 8'h13, XOFF2 = 8'h14;
  localparam logic [LVL_W-1:0] HI = 8'd10, LO = 8'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LVL_W-1:0] lvl = '0;
  logic enh = 1'b0, nine = 1'b0, rdy = 1'b0;
  logic [1:0] mode = 2'b00;
  logic req;
  logic [7:0] chr;
  logic thr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit m_req, m_thr, m_xoff;
  logic [7:0] m_chr;

  always #(CLK_P/2) clk = ~clk;

  xonxoff_inserter #(.LVL_W(LVL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_level_i(lvl), .thr_hi_i(HI), .thr_lo_i(LO),
    .enh_en_i(enh), .nine_bit_i(nine), .tx_mode_i(mode),
    .xon1_i(XON1), .xon2_i(XON2), .xoff1_i(XOFF1), .xoff2_i(XOFF2),
    .ins_ready_i(rdy), .ins_req_o(req), .ins_char_o(chr), .throttled_o(thr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit m_act();
    return enh && !nine && (mode == 2'b01 || mode == 2'b10);
  endfunction

  task automatic model_edge();
    if (!m_act()) begin
      m_req = 0; m_thr = 0;
    end else if (m_req && rdy) begin
      m_req = 0; m_thr = m_xoff;
    end else if (!m_req) begin
      if (!m_thr && lvl > HI) begin
        m_req = 1; m_xoff = 1; m_chr = (mode == 2'b10) ? XOFF1 : XOFF2;
      end else if (m_thr && lvl < LO) begin
        m_req = 1; m_xoff = 0; m_chr = (mode == 2'b10) ? XON1 : XON2;
      end
    end
  endtask

  // called at a negedge with inputs set; advances one cycle and compares
  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " req"}, {7'd0, req}, {7'd0, m_req});
    chk({tag, " thr"}, {7'd0, thr}, {7'd0, m_thr});
    if (m_req) chk({tag, " chr"}, chr, m_chr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rdy = 1'b0; lvl = '0;
    m_req = 0; m_thr = 0; m_xoff = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset req", {7'd0, req}, 8'd0);
    chk("R1 reset thr", {7'd0, thr}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // sweep every mode/enable/framing combination
    for (int cfg = 0; cfg < 16; cfg++) begin
      mode = cfg[1:0]; enh = cfg[2]; nine = cfg[3];
      do_reset();
      // R6: rising through the band raises nothing
      for (int l = 0; l <= HI; l++) begin
        lvl = LVL_W'(l); cyc("R6 rise");
      end
      // R2/R7: crossing the upper threshold
      lvl = HI + 1; cyc("R2 R7 over");
      chk("R2 R7 req", {7'd0, req}, {7'd0, m_act()});
      if (m_act()) chk("R2 xoff char", chr, (mode == 2'b10) ? XOFF1 : XOFF2);
      // R4: held while not ready
      for (int k = 0; k < 3; k++) cyc("R4 hold");
      rdy = 1'b1; cyc("R4 R5 accept"); rdy = 1'b0;
      chk("R5 throttled", {7'd0, thr}, {7'd0, m_act()});
      // R5: no second stop while still high
      for (int k = 0; k < 3; k++) cyc("R5 no repeat");
      chk("R5 no repeat req", {7'd0, req}, 8'd0);
      // R6: falling through the band raises nothing
      for (int l = HI; l >= LO; l--) begin
        lvl = LVL_W'(l); cyc("R6 fall");
      end
      // R3: dropping below the lower threshold
      lvl = LO - 1; cyc("R3 under");
      chk("R3 req", {7'd0, req}, {7'd0, m_act()});
      if (m_act()) chk("R3 xon char", chr, (mode == 2'b10) ? XON1 : XON2);
      rdy = 1'b1; cyc("R5 xon accept"); rdy = 1'b0;
      chk("R5 released", {7'd0, thr}, 8'd0);
    end

    // R8: disable while throttled and while a go request is pending
    enh = 1; nine = 0; mode = 2'b01; do_reset();
    lvl = HI + 1; cyc("R8 setup"); rdy = 1; cyc("R8 setup"); rdy = 0;
    lvl = 0; cyc("R8 pend");
    chk("R8 pending", {7'd0, req}, 8'd1);
    mode = 2'b11; cyc("R8 drop");
    chk("R8 req cleared", {7'd0, req}, 8'd0);
    chk("R8 thr cleared", {7'd0, thr}, 8'd0);
    mode = 2'b01; cyc("R8 back");
    chk("R8 no xon after", {7'd0, req}, 8'd0);

    // R9: disable in the same cycle as acceptance
    do_reset();
    lvl = HI + 1; cyc("R9 setup");
    rdy = 1; mode = 2'b00; cyc("R9 clash"); rdy = 0;
    chk("R9 thr stays 0", {7'd0, thr}, 8'd0);
    mode = 2'b10; lvl = HI;

    // stop accepted with level already below lower: go one cycle later
    do_reset();
    lvl = HI + 1; cyc("R3 setup");
    lvl = 0; rdy = 1; cyc("R3 accept"); rdy = 0;
    chk("R3 not same cycle", {7'd0, req}, 8'd0);
    cyc("R3 next");
    chk("R3 go follows", chr, XON1);

    // pseudo-random run against the model
    begin
      logic [15:0] lf = 16'hACE1;
      do_reset();
      for (int i = 0; i < 4000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        lvl = LVL_W'(lf[3:0]);
        rdy = lf[4];
        if (lf[9:5] == 5'd0) mode = lf[11:10];
        if (lf[14:12] == 3'd0) mode = 2'b01;
        cyc("R4 R5 random");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule